// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block runs the stack side of subroutine linkage and byte push/pop for a small processor core. It owns an 8-bit stack pointer into a 256-byte internal RAM. It drives one single-port RAM interface, with one access per clock. Reads are synchronous: data appears one cycle after the request.

The core issues one command at a time while `cmd_ready` is high. There are four commands:

- **Push** places a byte on the stack.
- **Pop** takes a byte off the stack.
- **Call** computes the return address from the current PC and the instruction length, stores it on the stack, and loads the target into the PC.
- **Return** rebuilds the PC from the stack.

Each command ends with a one-cycle `done` pulse. At that point `pop_byte` or `pc_out` holds the result.

The stack grows upward. A push pre-increments the pointer before its write. A pop reads first and then post-decrements. A call saves the low return byte before the high one. A return restores the bytes in the opposite order. Pointer arithmetic wraps modulo 256. Forming the target address and providing the RAM itself are left to the surrounding logic.

Top module: `callstack_seq`

## Requirements
- R1: On reset, `stack_ptr` is 0x07, `pc_out` is 0x0000, `done` is low and `cmd_ready` is high.
- R2: Push moves `stack_ptr` up by one and then writes `cmd_byte` at the new pointer value. `done` pulses 2 cycles after the accepting edge.
- R3: Pop reads the byte at `stack_ptr`, presents it on `pop_byte` with `done`, and moves `stack_ptr` down by one. `done` pulses 2 cycles after the accepting edge.
- R4: Call forms a return address as follows:
  - `pc_in + 3` when `cmd_long` is 1.
  - `pc_in + 2` when `cmd_long` is 0.
- R5: Call performs these steps in order:
  - Writes the low return byte at `stack_ptr + 1`.
  - Writes the high return byte at `stack_ptr + 2` on the next cycle.
  - Leaves `stack_ptr` raised by 2 and sets `pc_out` to `cmd_target`.

  `done` pulses 3 cycles after the accepting edge. Example: a long call at 0x3254 with pointer 0x07 stores 0x57 at 0x08 and 0x32 at 0x09.
- R6: Return performs these steps in order:
  - Reads the high PC byte at `stack_ptr`.
  - Reads the low byte at `stack_ptr - 1`.
  - Lowers `stack_ptr` by 2 and sets `pc_out` to {high, low}.

  `done` pulses 3 cycles after the accepting edge.
- R7: `done` lasts exactly one cycle. `cmd_ready` is low from the accepting edge until `done`. A command offered while `cmd_ready` is low is ignored and leaves `stack_ptr` and the RAM unchanged.
- R8: Every pointer step wraps modulo 256: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R9: The RAM interface never requests a read and a write in the same cycle.
- R10: Command codes on `cmd_op` are 0 for push, 1 for pop, 2 for call and 3 for return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | Command code (see R10) |
| cmd_byte | input | 8 | Byte to push |
| cmd_long | input | 1 | Call length select: 1 = three-byte, 0 = two-byte |
| cmd_target | input | 16 | Call destination address |
| pc_in | input | 16 | Address of the calling instruction |
| cmd_ready | output | 1 | Sequencer idle and accepting a command |
| done | output | 1 | One-cycle completion strobe |
| pop_byte | output | 8 | Byte returned by the last pop |
| pc_out | output | 16 | PC after the last call or return |
| stack_ptr | output | 8 | Current stack pointer |
| ram_we | output | 1 | RAM write request |
| ram_re | output | 1 | RAM read request |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_re` |

## Verification
Directed cases come first:

- **Long call at 0x3254.** With the pointer at reset, this checks the byte order and the +3 length.
- **Short call at 0x8549.** This separates the +2 length from the +3 length.
- **Two nested returns.** These show that high-then-low restoration undoes the call order exactly.
- **Pop command held during a busy push.** This shows commands are ignored while busy.
- **Run of pops from 0x07 down past zero, followed by a push.** This exposes wrap at both ends of the pointer.

A seeded random mix of all four commands follows. It is compared against a bench stack model, so misordered bytes, wrong latency or a pointer that drifts show up as mismatches in `pop_byte`, `pc_out`, `stack_ptr` or the RAM image.

// File: rtl/callstack_pkg.sv
package callstack_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } cs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CALL_LO,
        ST_CALL_HI,
        ST_RET_HI,
        ST_RET_LO
    } cs_state_e;

endpackage

// File: rtl/cs_sp_step.sv
module cs_sp_step #(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] sp_cur,
    output logic [AW-1:0] sp_up,
    output logic [AW-1:0] sp_down
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // modulo 2**AW by width truncation
    always_comb begin
        sp_up   = sp_cur + ONE;
        sp_down = sp_cur - ONE;
    end
endmodule

// File: rtl/cs_ret_addr.sv
module cs_ret_addr #(
    parameter int unsigned PCW      = 16,
    parameter int unsigned LEN_LONG = 3,
    parameter int unsigned LEN_ABS  = 2
) (
    input  logic [PCW-1:0] pc_cur,
    input  logic           is_long,
    output logic [PCW-1:0] ret_addr
);
    localparam logic [PCW-1:0] STEP_LONG = PCW'(LEN_LONG);
    localparam logic [PCW-1:0] STEP_ABS  = PCW'(LEN_ABS);

    always_comb begin
        ret_addr = pc_cur + (is_long ? STEP_LONG : STEP_ABS);
    end
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
    import callstack_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 8,
    parameter int unsigned PCW      = 16,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [DW-1:0]  cmd_byte,
    input  logic [PCW-1:0] cmd_target,
    input  logic [PCW-1:0] ret_calc,
    input  logic [AW-1:0]  sp_up,
    input  logic [AW-1:0]  sp_down,
    output logic [AW-1:0]  sp_now,
    output logic           cmd_ready,
    output logic           done,
    output logic [DW-1:0]  pop_byte,
    output logic [PCW-1:0] pc_out,
    output logic           ram_we,
    output logic           ram_re,
    output logic [AW-1:0]  ram_addr,
    output logic [DW-1:0]  ram_wdata,
    input  logic [DW-1:0]  ram_rdata
);
    localparam int unsigned HI_LSB = PCW - DW;

    typedef struct packed {
        cs_state_e      st;
        logic [AW-1:0]  sp;
        logic [DW-1:0]  hold;
        logic [PCW-1:0] ret;
        logic [PCW-1:0] tgt;
        logic [PCW-1:0] pc;
        logic [DW-1:0]  pop;
        logic           done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cs_op_e op_w;

    assign op_w = cs_op_e'(cmd_op);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = ctl_q.sp;
        ram_wdata = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_w)
                        OP_PUSH: begin
                            ctl_d.sp   = sp_up;
                            ctl_d.hold = cmd_byte;
                            ctl_d.st   = ST_PUSH;
                        end
                        OP_POP: begin
                            ram_re   = 1'b1;
                            ctl_d.sp = sp_down;
                            ctl_d.st = ST_POP;
                        end
                        OP_CALL: begin
                            ctl_d.ret = ret_calc;
                            ctl_d.tgt = cmd_target;
                            ctl_d.sp  = sp_up;
                            ctl_d.st  = ST_CALL_LO;
                        end
                        OP_RET: begin
                            ram_re   = 1'b1;
                            ctl_d.sp = sp_down;
                            ctl_d.st = ST_RET_HI;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUSH: begin
                ram_we     = 1'b1;
                ram_wdata  = ctl_q.hold;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            ST_POP: begin
                ctl_d.pop  = ram_rdata;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            ST_CALL_LO: begin
                ram_we    = 1'b1;
                ram_wdata = ctl_q.ret[DW-1:0];
                ctl_d.sp  = sp_up;
                ctl_d.st  = ST_CALL_HI;
            end
            ST_CALL_HI: begin
                ram_we     = 1'b1;
                ram_wdata  = ctl_q.ret[PCW-1:HI_LSB];
                ctl_d.pc   = ctl_q.tgt;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            ST_RET_HI: begin
                ctl_d.ret[PCW-1:HI_LSB] = ram_rdata;
                ram_re   = 1'b1;
                ctl_d.sp = sp_down;
                ctl_d.st = ST_RET_LO;
            end
            ST_RET_LO: begin
                ctl_d.pc   = {ctl_q.ret[PCW-1:HI_LSB], ram_rdata};
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.sp   <= SP_INIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sp_now    = ctl_q.sp;
    assign cmd_ready = (ctl_q.st == ST_IDLE);
    assign done      = ctl_q.done;
    assign pop_byte  = ctl_q.pop;
    assign pc_out    = ctl_q.pc;
endmodule

// File: rtl/callstack_seq.sv
module callstack_seq #(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 8,
    parameter int unsigned LEN_LONG = 3,
    parameter int unsigned LEN_ABS  = 2,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [DW-1:0]   cmd_byte,
    input  logic            cmd_long,
    input  logic [2*DW-1:0] cmd_target,
    input  logic [2*DW-1:0] pc_in,
    output logic            cmd_ready,
    output logic            done,
    output logic [DW-1:0]   pop_byte,
    output logic [2*DW-1:0] pc_out,
    output logic [AW-1:0]   stack_ptr,
    output logic            ram_we,
    output logic            ram_re,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [DW-1:0]   ram_rdata
);
    localparam int unsigned PCW = 2 * DW;

    logic [AW-1:0]  sp_w, sp_up_w, sp_down_w;
    logic [PCW-1:0] ret_w;

    cs_sp_step #(.AW(AW)) u_step (
        .sp_cur  (sp_w),
        .sp_up   (sp_up_w),
        .sp_down (sp_down_w)
    );

    cs_ret_addr #(.PCW(PCW), .LEN_LONG(LEN_LONG), .LEN_ABS(LEN_ABS)) u_ret (
        .pc_cur   (pc_in),
        .is_long  (cmd_long),
        .ret_addr (ret_w)
    );

    cs_ctrl #(.DW(DW), .AW(AW), .PCW(PCW), .SP_INIT(SP_INIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_byte   (cmd_byte),
        .cmd_target (cmd_target),
        .ret_calc   (ret_w),
        .sp_up      (sp_up_w),
        .sp_down    (sp_down_w),
        .sp_now     (sp_w),
        .cmd_ready  (cmd_ready),
        .done       (done),
        .pop_byte   (pop_byte),
        .pc_out     (pc_out),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata)
    );

    assign stack_ptr = sp_w;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 8,
    parameter int unsigned LEN_LONG = 3,
    parameter int unsigned LEN_ABS  = 2,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic [DW-1:0]   cmd_byte,
    input logic            cmd_long,
    input logic [2*DW-1:0] pc_in,
    input logic            cmd_ready,
    input logic            done,
    input logic [AW-1:0]   stack_ptr,
    input logic            ram_we,
    input logic            ram_re,
    input logic [AW-1:0]   ram_addr,
    input logic [DW-1:0]   ram_wdata
);
    localparam int unsigned PCW = 2 * DW;

    logic           fire;
    logic [PCW-1:0] exp_ret;
    assign fire    = cmd_valid && cmd_ready;
    assign exp_ret = pc_in + (cmd_long ? PCW'(LEN_LONG) : PCW'(LEN_ABS));

    a_r1_reset_sp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stack_ptr == SP_INIT && cmd_ready && !done));

    a_r2_push_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd0) |=>
            (ram_we && ram_addr == $past(stack_ptr) + 1'b1 && ram_wdata == $past(cmd_byte)));

    a_r3_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd1) |=> (stack_ptr == $past(stack_ptr) - 1'b1));

    a_r5_call_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd2) |=>
            (ram_we && ram_addr == $past(stack_ptr) + 1'b1 && ram_wdata == $past(exp_ret[DW-1:0])));

    a_r5_call_high_next: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd2) |=> ##1 (ram_we && ram_wdata == $past(exp_ret[PCW-1:DW], 2)));

    a_r6_ret_reads_top: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd3) |-> (ram_re && ram_addr == stack_ptr));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !cmd_ready);

    a_r9_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));
endmodule

bind callstack_seq cs_checker #(
    .DW(DW), .AW(AW), .LEN_LONG(LEN_LONG), .LEN_ABS(LEN_ABS), .SP_INIT(SP_INIT)
) u_cs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_long  (cmd_long),
    .pc_in     (pc_in),
    .cmd_ready (cmd_ready),
    .done      (done),
    .stack_ptr (stack_ptr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
);

// File: tb/callstack_seq_test.sv
module callstack_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_long = 1'b0;
    logic [15:0] cmd_target = '0;
    logic [15:0] pc_in = '0;
    logic        cmd_ready, done, ram_we, ram_re;
    logic [7:0]  pop_byte, stack_ptr, ram_addr, ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [15:0] pc_out;

    logic [7:0]  ram [256];
    logic [7:0]  mdl_mem [256];
    logic [7:0]  mdl_sp;
    logic [15:0] mdl_pc;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    callstack_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_long(cmd_long), .cmd_target(cmd_target),
        .pc_in(pc_in), .cmd_ready(cmd_ready), .done(done), .pop_byte(pop_byte),
        .pc_out(pc_out), .stack_ptr(stack_ptr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural single-port RAM, one-cycle read
    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= ram[ram_addr];
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ret_of(input logic [15:0] pc, input logic lng);
        return pc + (lng ? 16'd3 : 16'd2);
    endfunction

    // drive one command for one cycle; return cycles until done seen
    task automatic issue(input logic [1:0] op, input logic [7:0] b, input logic lng,
                         input logic [15:0] tgt, input logic [15:0] pc, output int lat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_long = lng;
        cmd_target = tgt; pc_in = pc;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 20) chk(1'b0, "R7 watchdog done", 32'(lat), 32'd3);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] b, input logic lng,
                         input logic [15:0] tgt, input logic [15:0] pc);
        int lat;
        logic [15:0] r;
        logic [7:0] hi, lo, a0, a1;
        issue(op, b, lng, tgt, pc, lat);
        case (op)
            2'd0: begin // R2 push
                mdl_sp = mdl_sp + 8'd1;
                mdl_mem[mdl_sp] = b;
                chk(lat == 2, "R2 push latency", 32'(lat), 32'd2);
                @(negedge clk);
                chk(ram[mdl_sp] == b, "R2 push byte in RAM", 32'(ram[mdl_sp]), 32'(b));
            end
            2'd1: begin // R3 pop
                chk(lat == 2, "R3 pop latency", 32'(lat), 32'd2);
                chk(pop_byte == mdl_mem[mdl_sp], "R3 pop byte", 32'(pop_byte), 32'(mdl_mem[mdl_sp]));
                mdl_sp = mdl_sp - 8'd1;
            end
            2'd2: begin // R4 R5 call
                r = ret_of(pc, lng);
                a0 = mdl_sp + 8'd1;
                a1 = mdl_sp + 8'd2;
                mdl_mem[a0] = r[7:0];
                mdl_mem[a1] = r[15:8];
                mdl_sp = a1;
                mdl_pc = tgt;
                chk(lat == 3, "R5 call latency", 32'(lat), 32'd3);
                chk(pc_out == tgt, "R5 call pc", 32'(pc_out), 32'(tgt));
                @(negedge clk);
                chk(ram[a0] == r[7:0], "R4 call low byte", 32'(ram[a0]), 32'(r[7:0]));
                chk(ram[a1] == r[15:8], "R4 call high byte", 32'(ram[a1]), 32'(r[15:8]));
            end
            default: begin // R6 return
                hi = mdl_mem[mdl_sp];
                lo = mdl_mem[8'(mdl_sp - 8'd1)];
                mdl_sp = mdl_sp - 8'd2;
                mdl_pc = {hi, lo};
                chk(lat == 3, "R6 return latency", 32'(lat), 32'd3);
                chk(pc_out == mdl_pc, "R6 return pc", 32'(pc_out), 32'(mdl_pc));
            end
        endcase
        chk(stack_ptr == mdl_sp, "R8 stack pointer", 32'(stack_ptr), 32'(mdl_sp));
    endtask

    initial begin
        int lat;
        logic [7:0] sp_before;
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'h00;
            mdl_mem[i] = 8'h00;
        end
        void'($urandom(32'd20240611));
        mdl_sp = 8'h07;
        mdl_pc = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(stack_ptr == 8'h07, "R1 reset sp", 32'(stack_ptr), 32'h07);
        chk(pc_out == 16'h0000, "R1 reset pc", 32'(pc_out), 32'h0);
        chk(!done && cmd_ready, "R1 reset done/ready", {30'd0, done, cmd_ready}, 32'h1);

        // R4 R5 long call at 0x3254: 0x57 at 0x08, 0x32 at 0x09
        do_op(2'd2, 8'h00, 1'b1, 16'h1234, 16'h3254);
        chk(ram[8'h08] == 8'h57, "R5 long call low at 08", 32'(ram[8'h08]), 32'h57);
        chk(ram[8'h09] == 8'h32, "R5 long call high at 09", 32'(ram[8'h09]), 32'h32);
        // R4 short call at 0x8549 -> 0x854B
        do_op(2'd2, 8'h00, 1'b0, 16'h0100, 16'h8549);
        chk(ram[8'h0A] == 8'h4B, "R4 short call low", 32'(ram[8'h0A]), 32'h4B);
        // R6 nested returns
        do_op(2'd3, 8'h00, 1'b0, 16'h0, 16'h0);
        chk(pc_out == 16'h854B, "R6 inner return", 32'(pc_out), 32'h854B);
        do_op(2'd3, 8'h00, 1'b0, 16'h0, 16'h0);
        chk(pc_out == 16'h3257, "R6 outer return", 32'(pc_out), 32'h3257);

        // R7 command held while busy is ignored
        sp_before = stack_ptr;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_byte = 8'h3C;
        @(negedge clk);
        chk(!cmd_ready, "R7 busy after accept", 32'(cmd_ready), 32'h0);
        cmd_op = 2'd1;          // pop offered while busy
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done, "R7 push done", 32'(done), 32'h1);
        @(negedge clk);
        chk(!done, "R7 done one cycle", 32'(done), 32'h0);
        chk(stack_ptr == 8'(sp_before + 8'd1), "R7 ignored pop", 32'(stack_ptr), 32'(sp_before + 8'd1));
        mdl_sp = sp_before + 8'd1;
        mdl_mem[mdl_sp] = 8'h3C;

        // R8 wrap downward past zero then push at 0x00
        while (mdl_sp != 8'hFF) do_op(2'd1, 8'h00, 1'b0, 16'h0, 16'h0);
        chk(stack_ptr == 8'hFF, "R8 wrap down", 32'(stack_ptr), 32'hFF);
        do_op(2'd0, 8'hA5, 1'b0, 16'h0, 16'h0);
        chk(ram[8'h00] == 8'hA5 && stack_ptr == 8'h00, "R8 wrap up", 32'(ram[8'h00]), 32'hA5);
        do_op(2'd1, 8'h00, 1'b0, 16'h0, 16'h0);
        chk(pop_byte == 8'hA5, "R3 wrapped pop", 32'(pop_byte), 32'hA5);

        // R2 R3 R5 R6 random mix
        for (int k = 0; k < 400; k++) begin
            do_op(2'($urandom_range(3, 0)), 8'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom));
        end
        issue(2'd0, 8'h00, 1'b0, 16'h0, 16'h0, lat);
        chk(lat == 2, "R10 push code", 32'(lat), 32'd2);

        report();
        $finish;
    end
endmodule